// File: doc/BRIEF.md
# Network Card Option Registers and Host Window Decoder

This block sits on the adapter side of a network card. It holds a small bank of option registers in eight consecutive I/O locations. Two of these return a fixed card identifier. One holds the card-enable and boot-ROM-disable bits. One holds the window base, and one holds an interrupt selector.

The window base register supplies host address bits 19:14. A 16 KB window of host memory space can therefore be placed on any 16 KB boundary. When the card is enabled and a host memory access falls inside that window, the decoder names the region that was hit: shared RAM, the station-address PROM, a reserved gap, a 16-bit data register, a status/control byte or a command byte. It raises one select strobe toward the downstream logic for that region.

The block also provides the window offset and a PROM byte index. It returns read data itself for the PROM and the gap.

Top module: `optwin_top`

## Requirements
- R1: After reset, offsets 2, 3 and 4 read 0x00. The card is therefore off, no region strobe is raised, and the boot ROM is reported on (`boot_rom_on` = 1).
- R2: I/O offset 0 always reads 0xFD and offset 1 always reads 0x6A. Writes to these offsets change no register.
- R3: Offset 2 bit 0 is the card enable (1 = on, driven on `card_on`). Bit 1 is the boot-ROM disable (1 = off, `boot_rom_on` is its inverse). Both bits read back, and bits 7:2 read 0. A write takes effect at the clock edge that samples it.
- R4: Offset 3 stores the window base in bits 5:0, matched against host address bits 19:14. Bits 7:6 read 0.
- R5: Offset 4 stores a 4-bit interrupt selector in bits 3:0, driven on `irq_sel`; bits 7:4 read 0. Offsets 5 to 7 read 0x00, and writes to them change no register.
- R6: A host access is claimed only when `mem_valid` is 1, the card enable is 1 and `mem_addr[19:14]` equals the stored base. Otherwise all six strobes are 0.
- R7: For a claimed access, the offset `mem_addr[13:0]` maps to the regions below, and exactly one strobe is 1.

  | Offset range | Strobe |
  |---|---|
  | 0x0000–0x3FBF | `sel_ram` |
  | 0x3FC0–0x3FDF | `sel_prom` |
  | 0x3FE0–0x3FEF and 0x3FF4–0x3FFF | `sel_rsvd` |
  | 0x3FF0–0x3FF1 | `sel_data` |
  | 0x3FF2 | `sel_ctl` |
  | 0x3FF3 | `sel_cmd` |

- R8: `win_offset` equals `mem_addr[13:0]`, and `prom_index` equals `mem_addr[4:1]`.
- R9: In the PROM region, an even address returns `prom_din` on `win_rdata` and an odd address returns 0xFF.
- R10: `win_rdata` is 0x00 whenever the PROM region is not selected, including the reserved gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe for the option registers |
| io_addr | input | 3 | Option register offset |
| io_wdata | input | 8 | Option register write data |
| io_rdata | output | 8 | Option register read data (combinational) |
| mem_valid | input | 1 | Host memory access present |
| mem_addr | input | 20 | Host memory address |
| prom_din | input | 8 | Byte from the station-address PROM |
| win_rdata | output | 8 | Read data returned for the PROM and the gap |
| win_offset | output | 14 | Offset inside the window |
| prom_index | output | 4 | PROM byte index (even-address number) |
| sel_ram | output | 1 | Shared RAM strobe |
| sel_prom | output | 1 | PROM strobe |
| sel_rsvd | output | 1 | Reserved gap strobe |
| sel_data | output | 1 | 16-bit data register strobe |
| sel_ctl | output | 1 | Status/control byte strobe |
| sel_cmd | output | 1 | Command byte strobe |
| card_on | output | 1 | Card enable bit |
| boot_rom_on | output | 1 | Boot ROM enabled |
| irq_sel | output | 4 | Interrupt selector |

## Verification
Directed accesses land on each edge of every region, at 0x3FBF/0x3FC0, 0x3FDF/0x3FE0, 0x3FEF/0x3FF0 and 0x3FF1 through 0x3FF4. These separate off-by-one errors in the region limits. Accesses whose base differs only in a single high address bit, and accesses with the card disabled, separate a correct base match from a partial compare or from missing enable gating. Random addresses, with the base matched half of the time and random PROM data, check even/odd PROM handling and data return against a bench model. Writes to the identifier and unused offsets are followed by reads of every register, to show that nothing was touched.

// File: rtl/optwin_pkg.sv
package optwin_pkg;
  localparam int WIN_W = 14;

  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_RAM  = 3'd1,
    RG_PROM = 3'd2,
    RG_RSVD = 3'd3,
    RG_DATA = 3'd4,
    RG_CTL  = 3'd5,
    RG_CMD  = 3'd6
  } region_e;

  localparam int NUM_REGIONS = 6;

  localparam logic [WIN_W-1:0] RAM_LIMIT  = 14'h3FC0;
  localparam logic [WIN_W-1:0] PROM_LIMIT = 14'h3FE0;
  localparam logic [WIN_W-1:0] GAP_LIMIT  = 14'h3FF0;
  localparam logic [WIN_W-1:0] DATA_LIMIT = 14'h3FF2;
  localparam logic [WIN_W-1:0] CTL_OFS    = 14'h3FF2;
  localparam logic [WIN_W-1:0] CMD_OFS    = 14'h3FF3;

  localparam logic [2:0] OFS_ID_LO  = 3'd0;
  localparam logic [2:0] OFS_ID_HI  = 3'd1;
  localparam logic [2:0] OFS_ENABLE = 3'd2;
  localparam logic [2:0] OFS_BASE   = 3'd3;
  localparam logic [2:0] OFS_IRQ    = 3'd4;
endpackage

// File: rtl/optwin_regs.sv
module optwin_regs
  import optwin_pkg::*;
#(
  parameter logic [7:0] ID_LO  = 8'hFD,
  parameter logic [7:0] ID_HI  = 8'h6A,
  parameter int         BASE_W = 6,
  parameter int         IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              card_en,
  output logic              rom_dis,
  output logic [BASE_W-1:0] base,
  output logic [IRQ_W-1:0]  irq
);
  localparam int BASE_PAD = 8 - BASE_W;
  localparam int IRQ_PAD  = 8 - IRQ_W;

  logic              card_q, card_d;
  logic              rom_q, rom_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic [IRQ_W-1:0]  irq_q, irq_d;
  logic              en_ctl, en_base, en_irq;

  always_comb begin
    en_ctl  = wr_en && (addr == OFS_ENABLE);
    en_base = wr_en && (addr == OFS_BASE);
    en_irq  = wr_en && (addr == OFS_IRQ);
    card_d  = en_ctl  ? wdata[0]          : card_q;
    rom_d   = en_ctl  ? wdata[1]          : rom_q;
    base_d  = en_base ? wdata[BASE_W-1:0] : base_q;
    irq_d   = en_irq  ? wdata[IRQ_W-1:0]  : irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      card_q <= 1'b0;
      rom_q  <= 1'b0;
      base_q <= '0;
      irq_q  <= '0;
    end else begin
      card_q <= card_d;
      rom_q  <= rom_d;
      base_q <= base_d;
      irq_q  <= irq_d;
    end
  end

  always_comb begin
    case (addr)
      OFS_ID_LO:  rdata = ID_LO;
      OFS_ID_HI:  rdata = ID_HI;
      OFS_ENABLE: rdata = {6'b0, rom_q, card_q};
      OFS_BASE:   rdata = {{BASE_PAD{1'b0}}, base_q};
      OFS_IRQ:    rdata = {{IRQ_PAD{1'b0}}, irq_q};
      default:    rdata = 8'h00;
    endcase
  end

  assign card_en = card_q;
  assign rom_dis = rom_q;
  assign base    = base_q;
  assign irq     = irq_q;
endmodule

// File: rtl/optwin_decode.sv
module optwin_decode
  import optwin_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                     valid,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     card_en,
  input  logic [ADDR_W-WIN_W-1:0]  base,
  output region_e                  region,
  output logic [WIN_W-1:0]         offset
);
  logic claim;

  always_comb begin
    offset = addr[WIN_W-1:0];
    claim  = valid && card_en && (addr[ADDR_W-1:WIN_W] == base);
    if (!claim)                  region = RG_NONE;
    else if (offset < RAM_LIMIT)  region = RG_RAM;
    else if (offset < PROM_LIMIT) region = RG_PROM;
    else if (offset < GAP_LIMIT)  region = RG_RSVD;
    else if (offset < DATA_LIMIT) region = RG_DATA;
    else if (offset == CTL_OFS)   region = RG_CTL;
    else if (offset == CMD_OFS)   region = RG_CMD;
    else                          region = RG_RSVD;
  end
endmodule

// File: rtl/optwin_top.sv
module optwin_top
  import optwin_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [2:0]        io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        prom_din,
  output logic [7:0]        win_rdata,
  output logic [WIN_W-1:0]  win_offset,
  output logic [3:0]        prom_index,
  output logic              sel_ram,
  output logic              sel_prom,
  output logic              sel_rsvd,
  output logic              sel_data,
  output logic              sel_ctl,
  output logic              sel_cmd,
  output logic              card_on,
  output logic              boot_rom_on,
  output logic [IRQ_W-1:0]  irq_sel
);
  localparam int BASE_W = ADDR_W - WIN_W;

  logic              card_en, rom_dis;
  logic [BASE_W-1:0] base;
  region_e           region;
  logic [NUM_REGIONS-1:0] sel_vec;

  optwin_regs #(.BASE_W(BASE_W), .IRQ_W(IRQ_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(io_wr), .addr(io_addr),
    .wdata(io_wdata), .rdata(io_rdata), .card_en(card_en),
    .rom_dis(rom_dis), .base(base), .irq(irq_sel)
  );

  optwin_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid(mem_valid), .addr(mem_addr), .card_en(card_en), .base(base),
    .region(region), .offset(win_offset)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_strobe
    assign sel_vec[g] = (region == region_e'(g + 1));
  end

  assign sel_ram  = sel_vec[0];
  assign sel_prom = sel_vec[1];
  assign sel_rsvd = sel_vec[2];
  assign sel_data = sel_vec[3];
  assign sel_ctl  = sel_vec[4];
  assign sel_cmd  = sel_vec[5];

  assign prom_index = win_offset[4:1];

  always_comb begin
    if (sel_prom) win_rdata = win_offset[0] ? 8'hFF : prom_din;
    else          win_rdata = 8'h00;
  end

  assign card_on     = card_en;
  assign boot_rom_on = ~rom_dis;
endmodule

// File: rtl/optwin_checker.sv
module optwin_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       io_wr,
  input logic [2:0] io_addr,
  input logic [7:0] io_rdata,
  input logic       mem_valid,
  input logic       mem_addr_lsb,
  input logic [7:0] win_rdata,
  input logic       sel_ram,
  input logic       sel_prom,
  input logic       sel_rsvd,
  input logic       sel_data,
  input logic       sel_ctl,
  input logic       sel_cmd,
  input logic       card_on,
  input logic       boot_rom_on,
  input logic [3:0] irq_sel
);
  logic [5:0] strobes;
  assign strobes = {sel_ram, sel_prom, sel_rsvd, sel_data, sel_ctl, sel_cmd};

  assert_id_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 3'd0) |-> (io_rdata == 8'hFD));
  assert_id_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == 3'd1) |-> (io_rdata == 8'h6A));
  assert_unused_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr >= 3'd5) |=> ($stable(irq_sel) && $stable(card_on) && $stable(boot_rom_on)));
  assert_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_on || !mem_valid) |-> (strobes == 6'b0));
  assert_one_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
  assert_prom_odd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_prom && mem_addr_lsb) |-> (win_rdata == 8'hFF));
  assert_quiet_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_prom |-> (win_rdata == 8'h00));
endmodule

bind optwin_top optwin_checker u_checker (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .io_rdata(io_rdata), .mem_valid(mem_valid), .mem_addr_lsb(mem_addr[0]),
  .win_rdata(win_rdata), .sel_ram(sel_ram), .sel_prom(sel_prom),
  .sel_rsvd(sel_rsvd), .sel_data(sel_data), .sel_ctl(sel_ctl),
  .sel_cmd(sel_cmd), .card_on(card_on), .boot_rom_on(boot_rom_on),
  .irq_sel(irq_sel)
);

// File: tb/test_optwin_top.sv
module test_optwin_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [2:0]  io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        mem_valid;
  logic [19:0] mem_addr;
  logic [7:0]  prom_din;
  logic [7:0]  win_rdata;
  logic [13:0] win_offset;
  logic [3:0]  prom_index;
  logic        sel_ram, sel_prom, sel_rsvd, sel_data, sel_ctl, sel_cmd;
  logic        card_on, boot_rom_on;
  logic [3:0]  irq_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic       m_card, m_romdis;
  logic [5:0] m_base;
  logic [3:0] m_irq;

  optwin_top i_optwin_top (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .prom_din(prom_din), .win_rdata(win_rdata),
    .win_offset(win_offset), .prom_index(prom_index), .sel_ram(sel_ram),
    .sel_prom(sel_prom), .sel_rsvd(sel_rsvd), .sel_data(sel_data),
    .sel_ctl(sel_ctl), .sel_cmd(sel_cmd), .card_on(card_on),
    .boot_rom_on(boot_rom_on), .irq_sel(irq_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_sel(input logic c, input logic [5:0] b, input logic v, input logic [19:0] a);
    logic [13:0] o;
    o = a[13:0];
    if (!(v && c && a[19:14] == b)) return 6'b0;
    if (o < 14'h3FC0) return 6'b100000;
    if (o < 14'h3FE0) return 6'b010000;
    if (o < 14'h3FF0) return 6'b001000;
    if (o < 14'h3FF2) return 6'b000100;
    if (o == 14'h3FF2) return 6'b000010;
    if (o == 14'h3FF3) return 6'b000001;
    return 6'b001000;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [5:0] s, input logic [19:0] a, input logic [7:0] p);
    if (s[4]) return a[0] ? 8'hFF : p;
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_io(input logic [2:0] a);
    case (a)
      3'd0: return 8'hFD;
      3'd1: return 8'h6A;
      3'd2: return {6'b0, m_romdis, m_card};
      3'd3: return {2'b0, m_base};
      3'd4: return {4'b0, m_irq};
      default: return 8'h00;
    endcase
  endfunction

  task automatic io_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
    case (a)
      3'd2: begin m_card = d[0]; m_romdis = d[1]; end
      3'd3: m_base = d[5:0];
      3'd4: m_irq = d[3:0];
      default: ;
    endcase
  endtask

  task automatic io_check_all(input string tag);
    for (int k = 0; k < 8; k++) begin
      io_addr = k[2:0];
      #1;
      check(io_rdata == exp_io(k[2:0]), tag, io_rdata, exp_io(k[2:0]));
    end
  endtask

  task automatic mem_check(input logic v, input logic [19:0] a, input logic [7:0] p, input string tag);
    logic [5:0] es, got;
    @(negedge clk);
    mem_valid = v; mem_addr = a; prom_din = p;
    #1;
    es  = exp_sel(m_card, m_base, v, a);
    got = {sel_ram, sel_prom, sel_rsvd, sel_data, sel_ctl, sel_cmd};
    check(got == es, tag, got, es);
    check(win_rdata == exp_rd(es, a, p), "R9/R10 rdata", win_rdata, exp_rd(es, a, p));
    check(win_offset == a[13:0] && prom_index == a[4:1], "R8 offset/index",
          {win_offset, prom_index}, {a[13:0], a[4:1]});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [19:0] a;
    logic [13:0] edges [10];
    seed = 32'd12345;
    void'($urandom(seed));
    rst_n = 1'b0; io_wr = 1'b0; io_addr = 3'd0; io_wdata = 8'h00;
    mem_valid = 1'b0; mem_addr = 20'h0; prom_din = 8'h00;
    m_card = 1'b0; m_romdis = 1'b0; m_base = 6'h0; m_irq = 4'h0;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    io_check_all("R1 reset register");
    check(boot_rom_on == 1'b1 && card_on == 1'b0, "R1 reset enables", {card_on, boot_rom_on}, 2'b01);
    mem_check(1'b1, 20'h00010, 8'h5A, "R1 no strobe after reset");

    // R2 identifier writes ignored, R5 unused offsets ignored
    io_write(3'd2, 8'h03); io_write(3'd3, 8'h2A); io_write(3'd4, 8'h09);
    io_write(3'd0, 8'h00); io_write(3'd1, 8'hFF);
    io_check_all("R2 id after writes");
    io_write(3'd5, 8'hFF); io_write(3'd6, 8'h00); io_write(3'd7, 8'h55);
    io_check_all("R5 unused offsets");
    check(irq_sel == 4'h9, "R5 irq output", irq_sel, 4'h9);

    // R3 / R4 / R5 upper bits read zero
    io_write(3'd2, 8'hFE); io_write(3'd3, 8'hFF); io_write(3'd4, 8'hF6);
    io_check_all("R3 R4 R5 masks");
    check(card_on == 1'b0 && boot_rom_on == 1'b0, "R3 enable outputs", {card_on, boot_rom_on}, 2'b00);
    io_write(3'd2, 8'h01);
    check(card_on == 1'b1 && boot_rom_on == 1'b1, "R3 card on rom on", {card_on, boot_rom_on}, 2'b11);

    // R6 gating
    io_write(3'd3, 8'h33);
    mem_check(1'b1, {6'h33, 14'h0100}, 8'h11, "R6 base match");
    mem_check(1'b1, {6'h13, 14'h0100}, 8'h11, "R6 base bit19 differs");
    mem_check(1'b1, {6'h32, 14'h0100}, 8'h11, "R6 base bit14 differs");
    mem_check(1'b0, {6'h33, 14'h0100}, 8'h11, "R6 no valid");
    io_write(3'd2, 8'h00);
    mem_check(1'b1, {6'h33, 14'h3FC0}, 8'h11, "R6 card off");
    io_write(3'd2, 8'h01);

    // R7 region edges
    edges[0] = 14'h0000; edges[1] = 14'h3FBF; edges[2] = 14'h3FC0; edges[3] = 14'h3FDF;
    edges[4] = 14'h3FE0; edges[5] = 14'h3FEF; edges[6] = 14'h3FF0; edges[7] = 14'h3FF2;
    edges[8] = 14'h3FF3; edges[9] = 14'h3FF4;
    foreach (edges[k]) mem_check(1'b1, {6'h33, edges[k]}, 8'hA5, "R7 region edge");
    mem_check(1'b1, {6'h33, 14'h3FF1}, 8'hA5, "R7 data high byte");
    mem_check(1'b1, {6'h33, 14'h3FFF}, 8'hA5, "R7 tail reserved");
    // R9 PROM even and odd
    mem_check(1'b1, {6'h33, 14'h3FC4}, 8'h3C, "R9 prom even");
    mem_check(1'b1, {6'h33, 14'h3FC5}, 8'h3C, "R9 prom odd");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) begin
        io_write(3'd2, 8'($urandom_range(0, 3)) | 8'h01 & 8'($urandom_range(0, 1) | (n % 100 == 0)));
        io_write(3'd3, 8'($urandom()));
        io_write(3'd4, 8'($urandom()));
        io_check_all("R3 R4 R5 random config");
      end
      a = 20'($urandom());
      if (($urandom() & 1) == 1) a[19:14] = m_base;
      if (($urandom() & 3) == 0) a[13:6] = 8'hFF;
      mem_check(1'($urandom()), a, 8'($urandom()), "R7 random access");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule